// File: doc/BRIEF.md
# Alarm Match and Interrupt Controller

This block watches a real-time clock's current BCD time and raises an alarm when the time equals a programmed target. There are six alarm target registers: seconds, minutes, hours, date, month and day of week. The top bit of each register decides whether that field takes part in the compare. A periodic alarm is built by enabling only some fields. For example, enabling the seconds field alone gives one alarm every minute.

A match sets a sticky alarm status flag and drives the active-low interrupt `irq_n`. The interrupt follows one of two modes. In latched mode it stays low until the host clears the flag. In recurring mode each match makes a pulse lasting a fixed number of 32.768 kHz enables, which is 250 ms at the default setting.

The host can clear status bits, but it can never set them by writing. The status bits can also clear themselves once a completed status read ends with a stop strobe. An alarm that arrives while such a read is still open survives that clear. The time counter and the serial bus sit outside the block. They deliver the `sec_tick` strobe with the updated time, and the `wr_*`, `rd_*` and `rd_stop` strobes.

The interrupt sequencer is a three-state machine:
- IRQ_IDLE: the interrupt is released.
- IRQ_HOLD: latched low.
- IRQ_PULSE: timed low.

Its transitions are:
- IDLE→HOLD: a match in latched mode.
- IDLE→PULSE: a match in recurring mode.
- HOLD→IDLE: the alarm flag is being cleared.
- HOLD→PULSE: a match after a switch to recurring mode.
- PULSE→PULSE: a match restarts the count.
- PULSE→IDLE: the last pulse enable has been counted.
- PULSE→HOLD: a match after a switch to latched mode.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is 1.
- R2: On a cycle with `sec_tick`=1 and the master enable set, the alarm flag (status bit 0) is set when every alarm register with bit 7 = 1 has its low field bits equal to the current time field. The field widths are 7, 7, 6, 6, 5 and 3 bits for seconds, minutes, hours, date, month and day of week. Registers with bit 7 = 0 are ignored. With no field enabled, every tick matches.
- R3: With the master enable (control bit 0) at 0, a tick never sets the alarm flag and never lowers `irq_n`.
- R4: The compare is sampled only on cycles with `sec_tick`=1. A matching time without the strobe has no effect.
- R5: In latched mode (control bit 1 = 0), `irq_n` goes low in the cycle after the match edge. It stays low until the clock edge that clears the alarm flag, and is 1 after that edge.
- R6: In recurring mode (control bit 1 = 1), a match sets the alarm flag and holds `irq_n` low for exactly PULSE_TICKS cycles in which `tick_32k`=1 (default 8192).
- R7: A match during an active pulse restarts the full PULSE_TICKS count.
- R8: A write to the status address (0) clears each flag whose data bit is 0. A data bit of 1 leaves the flag unchanged and can never set it.
- R9: A `batt_evt` strobe sets the battery flag, status bit 1.
- R10: With auto-clear on (control bit 2 = 1), a status read (`rd_en` with `rd_addr`=0) followed by `rd_stop` clears the flags that were set at the read. With auto-clear off, the flags stay set.
- R11: A flag that is set again between the status read and `rd_stop` stays set after the auto-clear.
- R12: Addresses 1 to 7 are written by `wr_en` and read back unchanged on `rd_data`. Address 1 is the control register and addresses 2 to 7 hold the alarm registers in field order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | 32.768 kHz enable strobe |
| sec_tick | input | 1 | Time has just advanced; compare now |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD, bit 5 is the PM flag in 12-hour mode |
| cur_date | input | 6 | Current date, BCD |
| cur_month | input | 5 | Current month, BCD |
| cur_wday | input | 3 | Current day of week 0..6 |
| batt_evt | input | 1 | Battery switchover event strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_stop | input | 1 | Read transfer completed with stop |
| rd_data | output | 8 | Read data for rd_addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The compare is tried with random enable masks against random valid BCD times. Each alarm field is equal to the current field or independently random, so a single mismatching enabled field and a mismatch in a disabled field are told apart. Directed patterns separate the strobe from the time: a matching time without `sec_tick`, and a matching tick with the master enable off. They also separate the two interrupt modes by pulse width, restart and release. The status bit patterns contrast write-0 against write-1, auto-clear on against off, and a flag set before the read against one set between the read and the stop.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NFIELD   = 6;
    localparam int FIELD_W  = 7;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_ALM0   = 3'd2;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_HOLD  = 2'd1,
        IRQ_PULSE = 2'd2
    } irq_state_e;

    // valid BCD bits per field: sec, min, hour, date, month, weekday
    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 7'h7F;
            2, 3:    field_mask = 7'h3F;
            4:       field_mask = 7'h1F;
            default: field_mask = 7'h07;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_irq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic                          ctrl_en,
    output logic                          ctrl_pulse,
    output logic                          ctrl_auto,
    output logic [NFIELD-1:0][DATA_W-1:0] alm_reg
);

    logic [2:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl_q <= wr_data[2:0];
        end
    end

    assign ctrl_en    = ctrl_q[0];
    assign ctrl_pulse = ctrl_q[1];
    assign ctrl_auto  = ctrl_q[2];

    for (genvar i = 0; i < NFIELD; i++) begin : g_alm
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_ALM0 + ADDR_W'(i);
        logic [DATA_W-1:0] reg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else if (wr_en && wr_addr == MY_ADDR) begin
                reg_q <= wr_data;
            end
        end
        assign alm_reg[i] = reg_q;
    end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_irq_pkg::*;
(
    input  logic                           sec_tick,
    input  logic                           enable,
    input  logic [NFIELD-1:0][DATA_W-1:0]  alm_reg,
    input  logic [NFIELD-1:0][FIELD_W-1:0] cur_vec,
    output logic                           hit
);

    logic [NFIELD-1:0] fld_ok;

    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        localparam logic [FIELD_W-1:0] MASK = field_mask(i);
        logic fld_en;
        logic fld_eq;
        assign fld_en    = alm_reg[i][DATA_W-1];
        assign fld_eq    = ((alm_reg[i][FIELD_W-1:0] & MASK) == (cur_vec[i] & MASK));
        assign fld_ok[i] = !fld_en || fld_eq;
    end

    assign hit = sec_tick && enable && (&fld_ok);

endmodule

// File: rtl/alarm_status.sv
module alarm_status
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_alm,
    input  logic set_bat,
    input  logic wr_status,
    input  logic [1:0] wr_bits,
    input  logic rd_status,
    input  logic rd_stop,
    input  logic auto_clr,
    output logic alm_q,
    output logic bat_q,
    output logic alm_nxt
);

    logic [1:0] flag_q, flag_d;
    logic [1:0] snap_q, snap_d;
    logic       pend_q, pend_d;
    logic [1:0] set_vec;

    assign set_vec = {set_bat, set_alm};

    always_comb begin
        flag_d = flag_q;
        snap_d = snap_q;
        pend_d = pend_q;
        if (wr_status) begin
            flag_d = flag_d & wr_bits;
        end
        if (rd_stop) begin
            if (pend_q && auto_clr) begin
                flag_d = flag_d & ~snap_q;
            end
            pend_d = 1'b0;
            snap_d = '0;
        end else if (rd_status) begin
            pend_d = 1'b1;
            snap_d = snap_q | flag_q;
        end
        // a fresh event wins over any clear and drops out of the snapshot
        flag_d = flag_d | set_vec;
        snap_d = snap_d & ~set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            snap_q <= '0;
            pend_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            snap_q <= snap_d;
            pend_q <= pend_d;
        end
    end

    assign alm_q   = flag_q[0];
    assign bat_q   = flag_q[1];
    assign alm_nxt = flag_d[0];

    AST_ALM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_alm |=> alm_q);  // R2
    AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_q && !set_alm) |=> !alm_q);  // R8
    AST_BAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_bat |=> bat_q);  // R9

endmodule

// File: rtl/alarm_irq_fsm.sv
module alarm_irq_fsm
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_TICKS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic pulse_mode,
    input  logic tick_32k,
    input  logic flag_nxt,
    output logic irq_n
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

    irq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (hit) begin
                    if (pulse_mode) begin
                        state_d = IRQ_PULSE;
                        cnt_d   = CNT_LOAD;
                    end else begin
                        state_d = IRQ_HOLD;
                    end
                end
            end
            IRQ_HOLD: begin
                if (hit && pulse_mode) begin
                    state_d = IRQ_PULSE;
                    cnt_d   = CNT_LOAD;
                end else if (!flag_nxt) begin
                    state_d = IRQ_IDLE;
                end
            end
            IRQ_PULSE: begin
                if (hit) begin
                    if (pulse_mode) begin
                        cnt_d = CNT_LOAD;
                    end else begin
                        state_d = IRQ_HOLD;
                    end
                end else if (tick_32k) begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = IRQ_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = IRQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_HOLD, IRQ_PULSE: irq_n = 1'b0;
            default:             irq_n = 1'b1;
        endcase
    end

    AST_PULSE_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PULSE) |-> (cnt_q != '0));  // R6
    AST_HIT_LOWERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !irq_n);  // R5
    AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pulse_mode) |=> (cnt_q == CNT_LOAD));  // R7

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       sec_tick,
    input  logic [6:0] cur_sec,
    input  logic [6:0] cur_min,
    input  logic [5:0] cur_hour,
    input  logic [5:0] cur_date,
    input  logic [4:0] cur_month,
    input  logic [2:0] cur_wday,
    input  logic       batt_evt,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    input  logic       rd_stop,
    output logic [7:0] rd_data,
    output logic       irq_n
);

    logic                           ctrl_en, ctrl_pulse, ctrl_auto;
    logic [NFIELD-1:0][DATA_W-1:0]  alm_reg;
    logic [NFIELD-1:0][FIELD_W-1:0] cur_vec;
    logic                           hit;
    logic                           alm_q, bat_q, alm_nxt;
    logic                           wr_status, rd_status;

    assign cur_vec[0] = cur_sec;
    assign cur_vec[1] = cur_min;
    assign cur_vec[2] = {1'b0, cur_hour};
    assign cur_vec[3] = {1'b0, cur_date};
    assign cur_vec[4] = {2'b0, cur_month};
    assign cur_vec[5] = {4'b0, cur_wday};

    assign wr_status = wr_en && (wr_addr == ADDR_STATUS);
    assign rd_status = rd_en && (rd_addr == ADDR_STATUS);

    alarm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ctrl_en    (ctrl_en),
        .ctrl_pulse (ctrl_pulse),
        .ctrl_auto  (ctrl_auto),
        .alm_reg    (alm_reg)
    );

    alarm_cmp u_cmp (
        .sec_tick (sec_tick),
        .enable   (ctrl_en),
        .alm_reg  (alm_reg),
        .cur_vec  (cur_vec),
        .hit      (hit)
    );

    alarm_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_alm   (hit),
        .set_bat   (batt_evt),
        .wr_status (wr_status),
        .wr_bits   (wr_data[1:0]),
        .rd_status (rd_status),
        .rd_stop   (rd_stop),
        .auto_clr  (ctrl_auto),
        .alm_q     (alm_q),
        .bat_q     (bat_q),
        .alm_nxt   (alm_nxt)
    );

    alarm_irq_fsm #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .pulse_mode (ctrl_pulse),
        .tick_32k   (tick_32k),
        .flag_nxt   (alm_nxt),
        .irq_n      (irq_n)
    );

    always_comb begin
        if (rd_addr == ADDR_STATUS) begin
            rd_data = {6'b0, bat_q, alm_q};
        end else if (rd_addr == ADDR_CTRL) begin
            rd_data = {5'b0, ctrl_auto, ctrl_pulse, ctrl_en};
        end else begin
            rd_data = alm_reg[rd_addr - ADDR_ALM0];
        end
    end

    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !hit);  // R3
    AST_NO_TICK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> !hit);  // R4

endmodule

// File: tb/alarm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb;

    localparam int PULSE_TICKS = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] cur_sec = '0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_date = '0;
    logic [4:0] cur_month = '0;
    logic [2:0] cur_wday = '0;
    logic       batt_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic       rd_stop = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alarm_irq_ctrl #(.PULSE_TICKS(PULSE_TICKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month), .cur_wday(cur_wday),
        .batt_evt(batt_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_stop(rd_stop), .rd_data(rd_data),
        .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] to_bcd(input int n);
        return 7'(((n / 10) << 4) | (n % 10));
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic status_read();
        @(negedge clk); rd_en = 1'b1; rd_addr = 3'd0;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic stop_strobe();
        @(negedge clk); rd_stop = 1'b1;
        @(negedge clk); rd_stop = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                            input logic [5:0] dt, input logic [4:0] mo, input logic [2:0] wd);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt; cur_month = mo; cur_wday = wd;
    endtask

    task automatic sec_strobe();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int cnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), d);
            check("R1 reset register", d, 8'h00);
        end
        check("R1 reset irq_n", irq_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 register write/readback
        for (int a = 1; a < 8; a++) begin
            logic [7:0] v;
            v = (a == 1) ? 8'h05 : 8'($urandom);
            wr(3'(a), v);
            peek(3'(a), d);
            check("R12 readback", d, v);
        end
        for (int a = 1; a < 8; a++) wr(3'(a), 8'h00);

        // R3 master enable off: every-field-disabled alarm would match every tick
        set_time(7'h12, 7'h34, 6'h05, 6'h06, 5'h07, 3'd2);
        sec_strobe();
        peek(3'd0, d);
        check("R3 flag with enable off", d[0], 1'b0);
        check("R3 irq_n with enable off", irq_n, 1'b1);

        // R2 no fields enabled: every tick matches
        wr(3'd1, 8'h01);
        sec_strobe();
        peek(3'd0, d);
        check("R2 empty mask matches", d[0], 1'b1);
        check("R5 irq_n low after match", irq_n, 1'b0);
        repeat (300) @(negedge clk);
        check("R5 irq_n held low", irq_n, 1'b0);
        // R8 write-1 cannot set, keeps flag
        wr(3'd0, 8'h03);
        peek(3'd0, d);
        check("R8 write one keeps flag", d[0], 1'b1);
        check("R5 irq_n still low", irq_n, 1'b0);
        clear_all();
        peek(3'd0, d);
        check("R8 write zero clears", d[0], 1'b0);
        check("R5 irq_n released after clear", irq_n, 1'b1);
        wr(3'd0, 8'h03);
        peek(3'd0, d);
        check("R8 write one on clear flags", d[1:0], 2'b00);

        // R4 matching time without the strobe
        wr(3'd2, 8'h80 | 8'h12);
        repeat (5) @(negedge clk);
        peek(3'd0, d);
        check("R4 no strobe no flag", d[0], 1'b0);
        check("R4 no strobe irq_n", irq_n, 1'b1);

        // R2 random compare
        for (int it = 0; it < 60; it++) begin
            int sv, mv, hv, dv, mov, wv;
            logic [5:0] en;
            logic [6:0] curv [6];
            logic [6:0] alv [6];
            logic exp_hit;
            sv = $urandom_range(59); mv = $urandom_range(59); hv = $urandom_range(23);
            dv = $urandom_range(31, 1); mov = $urandom_range(12, 1); wv = $urandom_range(6);
            curv[0] = to_bcd(sv); curv[1] = to_bcd(mv); curv[2] = to_bcd(hv);
            curv[3] = to_bcd(dv); curv[4] = to_bcd(mov); curv[5] = 7'(wv);
            en = 6'($urandom);
            exp_hit = 1'b1;
            for (int f = 0; f < 6; f++) begin
                if ($urandom_range(1) == 1) alv[f] = curv[f];
                else if (f == 5) alv[f] = 7'($urandom_range(6));
                else if (f == 0 || f == 1) alv[f] = to_bcd($urandom_range(59));
                else if (f == 2) alv[f] = to_bcd($urandom_range(23));
                else if (f == 3) alv[f] = to_bcd($urandom_range(31, 1));
                else alv[f] = to_bcd($urandom_range(12, 1));
                if (en[f] && alv[f] != curv[f]) exp_hit = 1'b0;
                wr(3'(f + 2), {en[f], alv[f]});
            end
            set_time(curv[0], curv[1], curv[2][5:0], curv[3][5:0], curv[4][4:0], curv[5][2:0]);
            sec_strobe();
            peek(3'd0, d);
            check("R2 random compare flag", d[0], exp_hit);
            check("R5 random compare irq_n", irq_n, !exp_hit);
            clear_all();
        end

        // R6 recurring pulse width; seconds-only alarm at 30
        for (int a = 2; a < 8; a++) wr(3'(a), 8'h00);
        wr(3'd2, 8'h80 | 8'h30);
        wr(3'd1, 8'h03);
        tick_32k = 1'b1;
        set_time(7'h30, 7'h00, 6'h00, 6'h01, 5'h01, 3'd0);
        sec_strobe();
        peek(3'd0, d);
        check("R6 flag in recurring mode", d[0], 1'b1);
        cnt = 1;
        while (irq_n == 1'b0 && cnt < PULSE_TICKS + 10) begin
            @(negedge clk);
            if (irq_n == 1'b0) cnt++;
        end
        check("R6 pulse length", cnt, PULSE_TICKS);
        peek(3'd0, d);
        check("R6 flag stays after pulse", d[0], 1'b1);
        clear_all();

        // R7 restart during pulse
        sec_strobe();
        repeat (100) @(negedge clk);
        sec_strobe();
        cnt = 1;
        while (irq_n == 1'b0 && cnt < PULSE_TICKS + 10) begin
            @(negedge clk);
            if (irq_n == 1'b0) cnt++;
        end
        check("R7 restarted pulse length", cnt, PULSE_TICKS);
        tick_32k = 1'b0;
        clear_all();

        // R9 battery flag; R10 auto-clear off keeps
        wr(3'd1, 8'h01);
        @(negedge clk); batt_evt = 1'b1;
        @(negedge clk); batt_evt = 1'b0;
        peek(3'd0, d);
        check("R9 battery flag set", d[1], 1'b1);
        sec_strobe();
        status_read();
        stop_strobe();
        peek(3'd0, d);
        check("R10 auto off keeps flags", d[1:0], 2'b11);
        // R10 auto-clear on
        wr(3'd1, 8'h05);
        status_read();
        stop_strobe();
        peek(3'd0, d);
        check("R10 auto clear flags", d[1:0], 2'b00);
        check("R10 irq_n released by auto clear", irq_n, 1'b1);

        // R11 alarm set between read and stop survives (flag clear at read)
        @(negedge clk); batt_evt = 1'b1;
        @(negedge clk); batt_evt = 1'b0;
        status_read();
        sec_strobe();
        stop_strobe();
        peek(3'd0, d);
        check("R11 new alarm survives", d[0], 1'b1);
        check("R11 old battery cleared", d[1], 1'b0);
        // R11 alarm set before read, set again before stop
        status_read();
        sec_strobe();
        stop_strobe();
        peek(3'd0, d);
        check("R11 re-set alarm survives", d[0], 1'b1);
        check("R11 irq_n still low", irq_n, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule